// File: doc/BRIEF.md
# Serial Word Transmitter with Selectable Clock and Frame Sync

This block moves 16-bit words from a host onto a single serial data pin. The host writes 32-bit values; each write becomes two 16-bit entries in a 30-entry queue, low half first. A frame-sync event takes the oldest entry into a 16-bit shift register. The register then sends the entry most significant bit first, one bit on each rising edge of the transmit clock.

The transmit clock comes either from the receive clock input or from the first general pin. The frame-sync event can come from an internal generator or from the second general pin. The internal generator counts transmit-clock edges and emits a pulse one edge long every N edges. The second general pin can serve as a frame-sync input, as a frame-sync output or as a plain output bit.

Both clock sources and the external frame-sync are sampled by the system clock `clk`. They pass through a synchronizer, and the rising edges of the selected clock become one-cycle ticks. If the queue is empty at a frame-sync event, the block sends a frame of zeros and raises an underrun flag. A write that finds too little room is dropped and raises an overflow flag. The interrupt request combines a fill-level threshold with the underrun flag.

Top module: `sst_tx`

## Requirements
- R1: When `cfg_clk_io1_i`=0 the transmit clock is `rx_clk_i`; when it is 1 the clock is `io1_i`. Edges on the unselected input change nothing.
- R2: The internal frame-sync is high for exactly one transmit-clock period in every N. N is `cfg_frame_len_i` clamped to the range 16..256, so 5 gives 16 and 300 gives 256. The generator counts every transmit-clock edge, whichever frame-sync source is selected.
- R3: When `cfg_fs_ext_i`=1, a word is loaded only at a transmit-clock rising edge where `io2_i` is high. Edges with `io2_i` low never load and never pop.
- R4: At a rising edge where frame-sync is high, the oldest queue entry is loaded and its bit 15 appears on `tx_data_o`. Each later rising edge shifts left by one, so bits 14 down to 0 follow and zeros come after them.
- R5: A host write pushes `host_wdata_i[15:0]` first and `host_wdata_i[31:16]` second. These are sent in that order.
- R6: A write that finds fewer than two free entries is dropped and sets `overflow_o`. Free space is counted before any pop in the same cycle, so the level then changes only by that pop. A write that finds at least two free entries is accepted even when a pop happens in the same cycle.
- R7: A load with an empty queue sends sixteen zeros and sets `underrun_o`.
- R8: `irq_o` is high one cycle after (`fifo_level_o` <= `cfg_irq_level_i`) or `underrun_o` holds.
- R9: The `cfg_io2_mode_i` encoding is as follows. 0 is frame-sync input, with `io2_oe_o`=0. 1 is frame-sync output, with `io2_oe_o`=1 and `io2_o` equal to the internal frame-sync. 2 is general output, with `io2_oe_o`=1 and `io2_o`=`cfg_io2_gp_i`. 3 is general input, with `io2_oe_o`=0.
- R10: `underrun_o` and `overflow_o` stay set until their clear input is pulsed. A set in the same cycle as a clear wins.
- R11: `fifo_level_o` is the number of queued entries, 0 to 30. After reset it is 0, and `tx_data_o`, `underrun_o` and `overflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_i | input | 1 | Receive clock, one transmit clock source |
| io1_i | input | 1 | First general pin, the other transmit clock source |
| io2_i | input | 1 | Second general pin, input side |
| io2_o | output | 1 | Second general pin, output value |
| io2_oe_o | output | 1 | Second general pin, output enable |
| tx_data_o | output | 1 | Serial transmit data |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data, two words |
| cfg_clk_io1_i | input | 1 | Transmit clock select |
| cfg_fs_ext_i | input | 1 | Frame-sync source select |
| cfg_io2_mode_i | input | 2 | Second pin mode |
| cfg_io2_gp_i | input | 1 | General output value for the second pin |
| cfg_frame_len_i | input | 9 | Internal frame period in transmit clocks |
| cfg_irq_level_i | input | 5 | Fill threshold for the interrupt |
| clr_underrun_i | input | 1 | Clears the underrun flag |
| clr_overflow_i | input | 1 | Clears the overflow flag |
| irq_o | output | 1 | Interrupt request |
| underrun_o | output | 1 | Sticky underrun flag |
| overflow_o | output | 1 | Sticky overflow flag |
| fifo_level_o | output | 5 | Queue fill level |

## Verification
A host write and a frame-sync pop can fall in the same system cycle. In that cycle the room test and the level update interact. The bench provokes this case by raising the selected serial clock and then driving the write strobe exactly two system cycles later. That is the cycle in which the synchronized edge pops. Before doing so, the bench confirms on `io2_o` that frame-sync is high. It runs the collision at a level of 29, where the write must be dropped and the level must fall to 28, and again at 28, where the write is accepted and the level must reach 29.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int SST_WORD_W      = 16;
    localparam int SST_DEPTH       = 30;
    localparam int SST_LEN_W       = 9;
    localparam int SST_MIN_LEN     = 16;
    localparam int SST_MAX_LEN     = 256;
    localparam int SST_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        IO2_FS_IN  = 2'd0,
        IO2_FS_OUT = 2'd1,
        IO2_GP_OUT = 2'd2,
        IO2_GP_IN  = 2'd3
    } io2_mode_e;

    typedef struct packed {
        logic tick;
        logic fs_ext;
    } edge_info_t;

    typedef struct packed {
        logic err_set;
        logic err_clr;
    } flag_ev_t;

    function automatic int unsigned clamp_len(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic next_flag(input logic cur, input flag_ev_t ev);
        if (ev.err_set) return 1'b1;
        if (ev.err_clr) return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/sst_edge.sv
module sst_edge
    import sst_pkg::*;
#(
    parameter int SYNC = SST_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_a_i,
    input  logic       src_b_i,
    input  logic       sel_b_i,
    input  logic       fs_raw_i,
    output edge_info_t info_o
);
    logic [SYNC-1:0] ch_a;
    logic [SYNC-1:0] ch_b;
    logic [SYNC-1:0] ch_fs;
    logic            prev;
    logic            cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_a  <= '0;
            ch_b  <= '0;
            ch_fs <= '0;
            prev  <= 1'b0;
        end else begin
            ch_a  <= {ch_a[SYNC-2:0], src_a_i};
            ch_b  <= {ch_b[SYNC-2:0], src_b_i};
            ch_fs <= {ch_fs[SYNC-2:0], fs_raw_i};
            prev  <= cur;
        end
    end

    always_comb begin
        cur            = sel_b_i ? ch_b[SYNC-1] : ch_a[SYNC-1];
        info_o.tick    = cur & ~prev;
        info_o.fs_ext  = ch_fs[SYNC-1];
    end
endmodule

// File: rtl/sst_fsgen.sv
module sst_fsgen
    import sst_pkg::*;
#(
    parameter int LEN_W   = SST_LEN_W,
    parameter int MIN_LEN = SST_MIN_LEN,
    parameter int MAX_LEN = SST_MAX_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fs_o
);
    localparam int CNT_W = $clog2(MAX_LEN);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = CNT_W'(clamp_len(int'(len_i), MIN_LEN, MAX_LEN) - 1);
        fs_o = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sst_fifo.sv
module sst_fifo
    import sst_pkg::*;
#(
    parameter int DEPTH = SST_DEPTH,
    parameter int W     = SST_WORD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push2_i,
    input  logic [W-1:0]               lo_i,
    input  logic [W-1:0]               hi_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rd_o,
    output logic                       empty_o,
    output logic                       push_ok_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [LW-1:0] level;
    logic [PW-1:0] wp1;
    logic          pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wp1       = nxt(wp);
        empty_o   = (level == '0);
        push_ok_o = push2_i && (level <= LW'(DEPTH - 2));
        pop_ok    = pop_i && !empty_o;
        rd_o      = mem[rp];
        level_o   = level;
    end

    always_ff @(posedge clk) begin
        if (push_ok_o) begin
            mem[wp]  <= lo_i;
            mem[wp1] <= hi_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok_o) wp <= nxt(wp1);
            if (pop_ok)    rp <= nxt(rp);
            level <= level + (push_ok_o ? LW'(2) : LW'(0)) - (pop_ok ? LW'(1) : LW'(0));
        end
    end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int W = SST_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         sd_o
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (tick_i) begin
            sr <= load_i ? word_i : {sr[W-2:0], 1'b0};
        end
    end

    assign sd_o = sr[W-1];
endmodule

// File: rtl/sst_tx.sv
module sst_tx
    import sst_pkg::*;
#(
    parameter int WORD_W  = SST_WORD_W,
    parameter int DEPTH   = SST_DEPTH,
    parameter int LEN_W   = SST_LEN_W,
    parameter int MIN_LEN = SST_MIN_LEN,
    parameter int MAX_LEN = SST_MAX_LEN,
    parameter int SYNC    = SST_SYNC_STAGES,
    localparam int HOST_W = 2 * WORD_W,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_clk_i,
    input  logic              io1_i,
    input  logic              io2_i,
    output logic              io2_o,
    output logic              io2_oe_o,
    output logic              tx_data_o,
    input  logic              host_wr_i,
    input  logic [HOST_W-1:0] host_wdata_i,
    input  logic              cfg_clk_io1_i,
    input  logic              cfg_fs_ext_i,
    input  logic [1:0]        cfg_io2_mode_i,
    input  logic              cfg_io2_gp_i,
    input  logic [LEN_W-1:0]  cfg_frame_len_i,
    input  logic [LVL_W-1:0]  cfg_irq_level_i,
    input  logic              clr_underrun_i,
    input  logic              clr_overflow_i,
    output logic              irq_o,
    output logic              underrun_o,
    output logic              overflow_o,
    output logic [LVL_W-1:0]  fifo_level_o
);
    edge_info_t      edge_info;
    logic            tick;
    logic            fs_int;
    logic            fs_sel;
    logic            load;
    logic            empty;
    logic            push_ok;
    logic [WORD_W-1:0] head;
    logic [WORD_W-1:0] load_word;
    io2_mode_e       mode;
    flag_ev_t        ur_ev;
    logic            flag_set_ov;
    flag_ev_t        ov_ev;

    sst_edge #(.SYNC(SYNC)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .src_a_i  (rx_clk_i),
        .src_b_i  (io1_i),
        .sel_b_i  (cfg_clk_io1_i),
        .fs_raw_i (io2_i),
        .info_o   (edge_info)
    );

    assign tick = edge_info.tick;

    sst_fsgen #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_fsgen (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .len_i  (cfg_frame_len_i),
        .fs_o   (fs_int)
    );

    always_comb begin
        fs_sel    = cfg_fs_ext_i ? edge_info.fs_ext : fs_int;
        load      = tick && fs_sel;
        load_word = empty ? '0 : head;
    end

    sst_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push2_i   (host_wr_i),
        .lo_i      (host_wdata_i[WORD_W-1:0]),
        .hi_i      (host_wdata_i[HOST_W-1:WORD_W]),
        .pop_i     (load),
        .rd_o      (head),
        .empty_o   (empty),
        .push_ok_o (push_ok),
        .level_o   (fifo_level_o)
    );

    sst_shifter #(.W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .load_i (load),
        .word_i (load_word),
        .sd_o   (tx_data_o)
    );

    always_comb begin
        ur_ev.err_set = load && empty;
        ur_ev.err_clr = clr_underrun_i;
        flag_set_ov   = host_wr_i && !push_ok;
        ov_ev.err_set = flag_set_ov;
        ov_ev.err_clr = clr_overflow_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun_o <= 1'b0;
            overflow_o <= 1'b0;
            irq_o      <= 1'b0;
        end else begin
            underrun_o <= next_flag(underrun_o, ur_ev);
            overflow_o <= next_flag(overflow_o, ov_ev);
            irq_o      <= (fifo_level_o <= cfg_irq_level_i) || underrun_o;
        end
    end

    always_comb begin
        mode = io2_mode_e'(cfg_io2_mode_i);
        unique case (mode)
            IO2_FS_OUT: begin io2_oe_o = 1'b1; io2_o = fs_int;       end
            IO2_GP_OUT: begin io2_oe_o = 1'b1; io2_o = cfg_io2_gp_i; end
            default:    begin io2_oe_o = 1'b0; io2_o = 1'b0;         end
        endcase
    end
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk #(
    parameter int DEPTH = 30,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             fs_int,
    input logic             load,
    input logic             host_wr_i,
    input logic [1:0]       cfg_io2_mode_i,
    input logic             io2_oe_o,
    input logic             underrun_o,
    input logic             overflow_o,
    input logic             irq_o,
    input logic [LVL_W-1:0] fifo_level_o
);
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level_o) <= DEPTH); // R11

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(fifo_level_o) <= int'($past(fifo_level_o)) + 2) &&
                 (int'(fifo_level_o) + 1 >= int'($past(fifo_level_o)))); // R5

    AST_FS_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && fs_int) |=> !fs_int); // R2

    AST_NO_ROOM: assert property (@(posedge clk) disable iff (rst)
        (host_wr_i && int'(fifo_level_o) > DEPTH - 2) |=> overflow_o); // R6

    AST_EMPTY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && fifo_level_o == '0) |=> underrun_o); // R7

    AST_UNDERRUN_IRQ: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> irq_o); // R8

    AST_PIN_INPUT: assert property (@(posedge clk) disable iff (rst)
        (cfg_io2_mode_i == 2'd0 || cfg_io2_mode_i == 2'd3) |-> !io2_oe_o); // R9
endmodule

bind sst_tx sst_tx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .fs_int         (fs_int),
    .load           (load),
    .host_wr_i      (host_wr_i),
    .cfg_io2_mode_i (cfg_io2_mode_i),
    .io2_oe_o       (io2_oe_o),
    .underrun_o     (underrun_o),
    .overflow_o     (overflow_o),
    .irq_o          (irq_o),
    .fifo_level_o   (fifo_level_o)
);

// File: tb/sst_tx_bench.sv
module sst_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_clk = 1'b0;
    logic        io1 = 1'b0;
    logic        io2_in = 1'b0;
    logic        io2_o;
    logic        io2_oe;
    logic        txd;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        clk_sel = 1'b0;
    logic        fs_sel = 1'b0;
    logic [1:0]  io2_mode = 2'd1;
    logic        gp_val = 1'b0;
    logic [8:0]  frame_len = 9'd16;
    logic [4:0]  thr = 5'd0;
    logic        urun_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        irq;
    logic        urun;
    logic        ovf;
    logic [4:0]  level;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  use_io1 = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    sst_tx u_sst_tx (
        .clk (clk), .rst (rst), .rx_clk_i (rx_clk), .io1_i (io1), .io2_i (io2_in),
        .io2_o (io2_o), .io2_oe_o (io2_oe), .tx_data_o (txd),
        .host_wr_i (wr), .host_wdata_i (wdata),
        .cfg_clk_io1_i (clk_sel), .cfg_fs_ext_i (fs_sel), .cfg_io2_mode_i (io2_mode),
        .cfg_io2_gp_i (gp_val), .cfg_frame_len_i (frame_len), .cfg_irq_level_i (thr),
        .clr_underrun_i (urun_clr), .clr_overflow_i (ovf_clr),
        .irq_o (irq), .underrun_o (urun), .overflow_o (ovf), .fifo_level_o (level)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] wlo(input int k);
        return 16'((k * 16'h1357) ^ 16'h00F0);
    endfunction

    function automatic logic [15:0] whi(input int k);
        return 16'((k * 16'h0101) + 16'h8000);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_src(input logic v);
        if (use_io1) io1 = v; else rx_clk = v;
    endtask

    task automatic pulse();
        set_src(1'b1);
        repeat (4) @(negedge clk);
        set_src(1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_fs();
        io2_in = 1'b1;
        repeat (4) @(negedge clk);
        set_src(1'b1);
        repeat (2) @(negedge clk);
        io2_in = 1'b0;
        repeat (2) @(negedge clk);
        set_src(1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] hi, input logic [15:0] lo);
        wr = 1'b1;
        wdata = {hi, lo};
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic capture(output logic [15:0] w, output int gap);
        gap = 0;
        while (!io2_o && gap < 300) begin
            pulse();
            gap++;
        end
        for (int b = 15; b >= 0; b--) begin
            pulse();
            w[b] = txd;
        end
    endtask

    task automatic collide(input logic [15:0] hi, input logic [15:0] lo);
        set_src(1'b1);
        @(negedge clk);
        @(negedge clk);
        wr = 1'b1;
        wdata = {hi, lo};
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        set_src(1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clr(input bit which_ovf);
        if (which_ovf) ovf_clr = 1'b1; else urun_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        urun_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int gap;
        int lens [6];
        int effs [6];
        lens = '{5, 16, 17, 20, 33, 300};
        effs = '{16, 16, 17, 20, 33, 256};

        do_reset();
        // R11 reset state
        chk("R11 level", level, 0);
        chk("R11 txd", txd, 0);
        chk("R11 underrun", urun, 0);
        chk("R11 overflow", ovf, 0);

        // R5 fill four writes, level climbs by two
        for (int k = 0; k < 4; k++) begin
            host_write(whi(k), wlo(k));
            chk("R5 level after write", level, 2 * (k + 1));
        end

        // R1 edges on unselected io1 do nothing
        use_io1 = 1'b1;
        for (int i = 0; i < 16; i++) pulse();
        use_io1 = 1'b0;
        chk("R1 unselected clock ignored", level, 8);
        chk("R9 fs out enable", io2_oe, 1);

        // R4 R5 R2 frames in order, back to back at N=16
        for (int k = 0; k < 4; k++) begin
            capture(w, gap);
            chk("R4 low word", w, wlo(k));
            chk("R2 gap N=16", gap, 0);
            capture(w, gap);
            chk("R4 high word", w, whi(k));
            chk("R11 level after pops", level, 8 - 2 * (k + 1));
        end

        // R7 underrun on empty load
        capture(w, gap);
        chk("R7 zero frame", w, 0);
        chk("R7 underrun flag", urun, 1);
        thr = 5'd0;
        host_write(whi(9), wlo(9));
        repeat (2) @(negedge clk);
        chk("R8 irq from underrun", irq, 1);
        pulse_clr(1'b0);
        chk("R10 underrun cleared", urun, 0);
        chk("R8 irq drops", irq, 0);

        // R2 frame length sweep including clamps
        for (int j = 0; j < 6; j++) begin
            frame_len = 9'(lens[j]);
            capture(w, gap);
            capture(w, gap);
            chk("R2 frame period", gap + 16, effs[j]);
        end

        // R8 threshold sweep over all levels
        frame_len = 9'd16;
        do_reset();
        for (int k = 0; k <= 15; k++) begin
            if (k > 0) host_write(whi(k - 1), wlo(k - 1));
            for (int t = 0; t <= 30; t++) begin
                thr = 5'(t);
                repeat (2) @(negedge clk);
                chk("R8 irq threshold", irq, (2 * k <= t) ? 1 : 0);
            end
        end
        chk("R11 full", level, 30);

        // R6 overflow when full
        host_write(16'hDEAD, 16'hBEEF);
        chk("R6 overflow set", ovf, 1);
        chk("R6 level kept", level, 30);
        pulse_clr(1'b1);
        chk("R10 overflow cleared", ovf, 0);
        capture(w, gap);
        chk("R5 first queued word", w, wlo(0));
        chk("R6 level 29", level, 29);
        host_write(16'h1111, 16'h2222);
        chk("R6 one free drops", ovf, 1);
        chk("R6 level stays 29", level, 29);
        pulse_clr(1'b1);

        // R6 collision of write and pop
        chk("R2 fs high before collision", io2_o, 1);
        collide(16'h3333, 16'h4444);
        chk("R6 collision at 29 dropped", level, 28);
        chk("R6 collision overflow", ovf, 1);
        pulse_clr(1'b1);
        for (int i = 0; i < 15; i++) pulse();
        chk("R2 fs high again", io2_o, 1);
        collide(16'h5555, 16'h6666);
        chk("R6 collision at 28 accepted", level, 29);
        chk("R6 no overflow", ovf, 0);

        // R3 R1 external frame sync on io1 clock
        do_reset();
        fs_sel = 1'b1;
        clk_sel = 1'b1;
        use_io1 = 1'b1;
        io2_mode = 2'd0;
        @(negedge clk);
        chk("R9 fs in no drive", io2_oe, 0);
        host_write(16'hC3A5, 16'h5A0F);
        for (int i = 0; i < 20; i++) pulse();
        chk("R3 no load without fs", level, 2);
        chk("R3 line idle", txd, 0);
        pulse_fs();
        w[15] = txd;
        for (int b = 14; b >= 0; b--) begin
            pulse();
            w[b] = txd;
        end
        chk("R3 external low word", w, 16'h5A0F);
        chk("R1 io1 clock pops", level, 1);
        pulse_fs();
        w[15] = txd;
        for (int b = 14; b >= 0; b--) begin
            pulse();
            w[b] = txd;
        end
        chk("R3 external high word", w, 16'hC3A5);
        pulse();
        chk("R4 zeros after word", txd, 0);

        // R9 pin modes
        io2_mode = 2'd2;
        gp_val = 1'b1;
        @(negedge clk);
        chk("R9 gp out enable", io2_oe, 1);
        chk("R9 gp out one", io2_o, 1);
        gp_val = 1'b0;
        @(negedge clk);
        chk("R9 gp out zero", io2_o, 0);
        io2_mode = 2'd3;
        @(negedge clk);
        chk("R9 gp in no drive", io2_oe, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule